// File: doc/BRIEF.md
# Message pending flag allocator

This block keeps two 32-bit banks of message-pending flags for a CAN-style message controller. Each time a message object completes a transmit or receive event, it raises a one-cycle set request. The request carries the object's 6-bit pending number, its transmit and receive node pointers, and a direction bit. The block then sets exactly one flag. A 4-bit allocation mode decides where that flag lands. In the plain mode the location comes only from the pending number. In the split mode, bits of the node pointer for the event's direction also take part, so receive and transmit events can land in different places.

Software reads the banks through a small register port and clears flags by writing zeros. Any bit written as one keeps its current value, so a flag that hardware sets in the same cycle as a software write is never lost. For each bank the block also gives a lowest-set-bit index. The index is combinational from the bank, so it is valid in the same cycle as the bank's new value.

Top module: `msg_pend_alloc`

## Requirements
- R1: After reset both banks hold zero and both index outputs read 32.
- R2: With mode 4'b0000, a set request sets the bit in bank pnum[5] at bit position pnum[4:0].
- R3: With mode 4'b1111 and a transmit event (set_is_tx=1), the bank is tx_nptr[1] and the bit position is {tx_nptr[0], pnum[3:0]}.
- R4: With mode 4'b1111 and a receive event (set_is_tx=0), the bank is rx_nptr[1] and the bit position is {rx_nptr[0], pnum[3:0]}. The transmit pointer is then ignored.
- R5: Any mode value other than 4'b0000 and 4'b1111 places the flag in the same way as 4'b0000.
- R6: A write to address 0 or 1 clears every bit of that bank written as 0 and leaves every bit written as 1 unchanged. The other bank is not affected.
- R7: When a set request and a software write target the same bank in the same cycle, the set flag ends up as 1, even if the write has a 0 at that bit position.
- R8: Each index output equals the lowest bit position holding a 1 in its bank, and it is valid in the same cycle as the bank value it describes.
- R9: When a bank is all zeros, its index output reads 32 (6'b100000).
- R10: Read address 0 returns bank 0, address 1 returns bank 1, address 2 returns index 0 and address 3 returns index 1, both zero-extended. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_mode | input | 4 | Allocation mode: 4'b1111 selects split placement; any other value selects plain placement |
| set_valid | input | 1 | One-cycle set request from a message object |
| set_is_tx | input | 1 | 1 for a transmit event, 0 for a receive event |
| set_pnum | input | 6 | Pending number of the requesting object |
| set_tx_nptr | input | 3 | Transmit node pointer of the requesting object |
| set_rx_nptr | input | 3 | Receive node pointer of the requesting object |
| reg_addr | input | 2 | Register port address |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 32 | Write data; bits written as 0 clear flags |
| reg_rdata | output | 32 | Combinational read data |
| pend_idx0 | output | 6 | Lowest set bit of bank 0, or 32 when the bank is empty |
| pend_idx1 | output | 6 | Lowest set bit of bank 1, or 32 when the bank is empty |

## Verification
The two functions that can fall in the same cycle are a hardware set request and a software clear-write to the same bank. The bench provokes this by driving both in a single cycle. In one case the write holds a zero at exactly the bit the request sets. In another the write is all zeros while the request sets a different bit. Both are judged by reading the bank and its index in the next cycle: the set flag must be present, and only the bits written as zero may be gone.

// File: rtl/msg_pend_alloc.sv
module msg_pend_alloc #(
  parameter int PNUM_W = 6,
  parameter int NPTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        alloc_mode,
  input  logic              set_valid,
  input  logic              set_is_tx,
  input  logic [PNUM_W-1:0] set_pnum,
  input  logic [NPTR_W-1:0] set_tx_nptr,
  input  logic [NPTR_W-1:0] set_rx_nptr,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [5:0]        pend_idx0,
  output logic [5:0]        pend_idx1
);
  localparam int FLAG_W = 32;
  localparam int IDX_W  = 6;
  localparam int POS_W  = 5;

  function automatic logic [IDX_W-1:0] lowest_one(input logic [FLAG_W-1:0] v);
    lowest_one = IDX_W'(FLAG_W);
    for (int i = FLAG_W - 1; i >= 0; i--)
      if (v[i]) lowest_one = IDX_W'(i);
  endfunction

  logic [1:0][FLAG_W-1:0] pend;
  logic [1:0][IDX_W-1:0]  idx;
  logic                   split;
  logic [NPTR_W-1:0]      nptr;
  logic                   sel_bank;
  logic [POS_W-1:0]       sel_pos;
  logic [FLAG_W-1:0]      set_mask;

  assign split    = (alloc_mode == 4'b1111);
  assign nptr     = set_is_tx ? set_tx_nptr : set_rx_nptr;
  assign sel_bank = split ? nptr[1] : set_pnum[5];
  assign sel_pos  = split ? {nptr[0], set_pnum[3:0]} : set_pnum[4:0];
  assign set_mask = FLAG_W'(1) << sel_pos;

  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic              wr_hit;
    logic              set_hit;
    logic [FLAG_W-1:0] kept;

    assign wr_hit  = reg_we && (reg_addr == 2'(k));
    assign set_hit = set_valid && (sel_bank == 1'(k));
    assign kept    = wr_hit ? (pend[k] & reg_wdata) : pend[k];
    assign idx[k]  = lowest_one(pend[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) pend[k] <= '0;
      else        pend[k] <= kept | (set_hit ? set_mask : '0);
    end
  end

  assign pend_idx0 = idx[0];
  assign pend_idx1 = idx[1];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pend[0];
      2'd1:    reg_rdata = pend[1];
      2'd2:    reg_rdata = {{(FLAG_W-IDX_W){1'b0}}, idx[0]};
      default: reg_rdata = {{(FLAG_W-IDX_W){1'b0}}, idx[1]};
    endcase
  end
endmodule

// File: rtl/msg_pend_alloc_chk.sv
module msg_pend_alloc_chk (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        alloc_mode,
  input logic              set_valid,
  input logic              set_is_tx,
  input logic [5:0]        set_pnum,
  input logic [2:0]        set_tx_nptr,
  input logic [2:0]        set_rx_nptr,
  input logic [1:0]        reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [1:0][31:0]  pend,
  input logic [5:0]        pend_idx0,
  input logic [5:0]        pend_idx1
);
  logic [2:0] ptr;
  logic       exp_bank;
  int         exp_pos;

  always_comb begin
    ptr = set_is_tx ? set_tx_nptr : set_rx_nptr;
    if (alloc_mode == 4'hF) begin
      exp_bank = ptr[1];
      exp_pos  = 16 * int'(ptr[0]) + int'(set_pnum[3:0]);
    end else begin
      exp_bank = set_pnum[5];
      exp_pos  = int'(set_pnum[4:0]);
    end
  end

  p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> pend[$past(exp_bank)][$past(exp_pos)] == 1'b1);

  p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && !set_valid) |=> pend[0] == $past(pend[0] & reg_wdata));

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_valid && (!reg_we || reg_addr[1])) |=> $stable(pend));

  p_empty_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] == '0) |-> pend_idx0 == 6'd32);

  p_lowest_idx0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_idx0 < 6'd32) |-> (pend[0][pend_idx0[4:0]] &&
      ((pend[0] & ((32'd1 << pend_idx0[4:0]) - 32'd1)) == '0)));

  p_lowest_idx1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_idx1 < 6'd32) |-> (pend[1][pend_idx1[4:0]] &&
      ((pend[1] & ((32'd1 << pend_idx1[4:0]) - 32'd1)) == '0)));
endmodule

bind msg_pend_alloc msg_pend_alloc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .alloc_mode(alloc_mode), .set_valid(set_valid),
  .set_is_tx(set_is_tx), .set_pnum(set_pnum), .set_tx_nptr(set_tx_nptr),
  .set_rx_nptr(set_rx_nptr), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .pend(pend), .pend_idx0(pend_idx0), .pend_idx1(pend_idx1)
);

// File: tb/test_msg_pend_alloc.sv
module test_msg_pend_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alloc_mode = '0;
  logic        set_valid = 1'b0;
  logic        set_is_tx = 1'b0;
  logic [5:0]  set_pnum = '0;
  logic [2:0]  set_tx_nptr = '0;
  logic [2:0]  set_rx_nptr = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  pend_idx0, pend_idx1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msg_pend_alloc i_msg_pend_alloc (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic cycle(input bit sv, input logic [3:0] m, input bit tx, input logic [5:0] pn,
                       input logic [2:0] tp, input logic [2:0] rp,
                       input bit we, input logic [1:0] a, input logic [31:0] wd);
    @(negedge clk);
    set_valid = sv; alloc_mode = m; set_is_tx = tx; set_pnum = pn;
    set_tx_nptr = tp; set_rx_nptr = rp; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    set_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic t_reset;
    rd(2'd0, "R1 bank0", 32'h0);
    rd(2'd1, "R1 bank1", 32'h0);
    rd(2'd2, "R1/R9 idx0", 32'd32);
    rd(2'd3, "R1/R9 idx1", 32'd32);
  endtask

  task automatic t_plain;
    cycle(1, 4'h0, 0, 6'b100101, 3'b000, 3'b000, 0, 2'd0, 0);
    rd(2'd1, "R2 bank1", 32'h0000_0020);
    rd(2'd0, "R2 bank0 untouched", 32'h0);
    check("R8 idx1", {26'b0, pend_idx1}, 32'd5);
  endtask

  task automatic t_other_mode;
    cycle(1, 4'h5, 1, 6'b000011, 3'b011, 3'b011, 0, 2'd0, 0);
    rd(2'd0, "R5 bank0", 32'h0000_0008);
    rd(2'd2, "R5/R10 idx0 read", 32'd3);
  endtask

  task automatic t_split_tx;
    cycle(1, 4'hF, 1, 6'b110110, 3'b011, 3'b000, 0, 2'd0, 0);
    rd(2'd1, "R3 bank1", 32'h0040_0020);
    rd(2'd0, "R3 bank0 untouched", 32'h0000_0008);
  endtask

  task automatic t_split_rx;
    cycle(1, 4'hF, 0, 6'b000010, 3'b011, 3'b001, 0, 2'd0, 0);
    rd(2'd0, "R4 bank0", 32'h0004_0008);
    rd(2'd1, "R4 bank1 untouched", 32'h0040_0020);
  endtask

  task automatic t_sw_clear;
    cycle(0, 4'h0, 0, 0, 0, 0, 1, 2'd0, ~32'h0000_0008);
    rd(2'd0, "R6 bank0", 32'h0004_0000);
    rd(2'd1, "R6 other bank", 32'h0040_0020);
    check("R8 idx0 follows", {26'b0, pend_idx0}, 32'd18);
  endtask

  task automatic t_index_write;
    cycle(0, 4'h0, 0, 0, 0, 0, 1, 2'd2, 32'h0);
    rd(2'd0, "R10 bank0 after idx write", 32'h0004_0000);
    cycle(0, 4'h0, 0, 0, 0, 0, 1, 2'd3, 32'h0);
    rd(2'd1, "R10 bank1 after idx write", 32'h0040_0020);
  endtask

  task automatic t_collide;
    cycle(1, 4'h0, 0, 6'b000000, 0, 0, 1, 2'd0, 32'hFFFF_FFFE);
    rd(2'd0, "R7 same bit", 32'h0004_0001);
    check("R8 idx0 zero", {26'b0, pend_idx0}, 32'd0);
    cycle(1, 4'h0, 0, 6'b000111, 0, 0, 1, 2'd0, 32'h0);
    rd(2'd0, "R7 clear all but set", 32'h0000_0080);
    check("R8 idx0 seven", {26'b0, pend_idx0}, 32'd7);
  endtask

  task automatic t_empty;
    cycle(0, 4'h0, 0, 0, 0, 0, 1, 2'd1, 32'h0);
    rd(2'd3, "R9 idx1 empty", 32'd32);
    cycle(0, 4'h0, 0, 0, 0, 0, 1, 2'd0, 32'h0);
    check("R9 idx0 empty", {26'b0, pend_idx0}, 32'd32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_other_mode();
    t_split_tx();
    t_split_rx();
    t_sw_clear();
    t_index_write();
    t_collide();
    t_empty();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule